// File: doc/BRIEF.md
# Prescaled Free-Running Tick Timer

This block is a register-mapped up-counting timer that produces periodic tick interrupts. A prescaler divides the input clock by a programmable amount. Each time the prescaler wraps, the main counter advances by one. A single compare register is checked against the counter. When the counter reaches the compare value and that interrupt is enabled, a status bit is set and the interrupt line rises. The counter keeps counting through a match. To get periodic ticks, software adds its tick interval to the compare register after each interrupt. The counter wraps with modulo arithmetic, so software can take the signed difference between the compare value and the counter to find out whether the compare point has already passed.

Software starts the timer through a control register. It clears the counter by setting a zeroing bit and then polling until the counter reads zero. A debug input can freeze counting while a debugger holds the chip, but only when software has allowed that. Access is through a simple bus: a write completes in a single cycle, and read data is combinational. All offsets are byte addresses of 32-bit words, and bits [1:0] of the address must be zero for an access to hit a register.

Top module: `tick_timer`

## Requirements
- R1: The counter (read at 0x04) only ever moves upward, by exactly one on each prescaler wrap, and wraps from all-ones to zero modulo 2^CNT_W.
- R2: With prescale limit P written at 0x0C, the prescaler counts 0..P and then restarts at 0. The counter therefore advances once every P+1 enabled cycles. P=12 turns a 13 MHz clock into 1 MHz steps.
- R3: The counter and the prescaler advance only while the run bit (bit 0 of control at 0x00) is 1.
- R4: While the zeroing bit (bit 1 of control) is 1, the counter and the prescaler read as zero from the clock edge after that bit is written, whether or not the run bit is set.
- R5: When the freeze-permit bit (bit 2 of control) is 1 and dbg_active is high, the counter and the prescaler hold their values. When the permit bit is 0, dbg_active has no effect.
- R6: On the clock edge where the counter takes the value held in compare register 0 (0x14), status bit 0 (0x08) is set, provided enable bit 0 of the interrupt-enable register (0x10) is 1. irq is high whenever an enabled status bit is 1.
- R7: Writing 1 to bit 0 of status clears it, and writing 0 leaves it unchanged. If a clearing write lands on the same edge as a new match, the bit stays set.
- R8: A match neither clears nor stops the counter. Software may rewrite compare register 0 at any time, and later matches use the new value.
- R9: The counter cannot be written. A write to 0x04 leaves its value and progression unchanged.
- R10: After reset all six registers read zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] must be zero |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| dbg_active | input | 1 | High while a debug probe holds the chip |
| irq | output | 1 | OR of enabled status bits |

## Verification
The collision that matters is a software write that clears status bit 0 arriving on the same edge as the counter stepping onto the compare value. The bench runs the prescaler at divide-by-one and rewrites the compare register so that its next match falls a known number of edges ahead. It then times a write of 1 to the status register so that it lands exactly on the matching edge. The check passes if the status bit still reads 1 afterwards, and a follow-up clear on the next edge must bring it to 0.

// File: rtl/tmr_pkg.sv
`timescale 1ns/10ps
package tmr_pkg;
  localparam int DATA_W = 32;

  // word index of each register (byte offset / 4)
  localparam logic [2:0] WI_CTRL = 3'd0;
  localparam logic [2:0] WI_CNT  = 3'd1;
  localparam logic [2:0] WI_STAT = 3'd2;
  localparam logic [2:0] WI_PLIM = 3'd3;
  localparam logic [2:0] WI_IEN  = 3'd4;
  localparam logic [2:0] WI_CMP0 = 3'd5;

  typedef struct packed {
    logic frz_ok;  // bit 2
    logic zero;    // bit 1
    logic run;     // bit 0
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/10ps
module tmr_prescale #(
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             at_lim;

  always_comb begin
    at_lim = (pre_q >= limit);
    tick   = run & ~clr & at_lim;
    pre_d  = pre_q;
    if (clr)
      pre_d = '0;
    else if (run)
      pre_d = at_lim ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_PRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0)); // R4
  AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pre_q)); // R5
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/10ps
module tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_d, cnt_inc;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    hit     = step & ~clr & (cnt_inc == cmp_val);
    cnt_d   = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (step)
      cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R4
  AST_CNT_UPWARD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))))); // R1
  AST_HIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt_q == $past(cmp_val))); // R6
endmodule

// File: rtl/tmr_irq.sv
`timescale 1ns/10ps
module tmr_irq #(
  parameter int NSRC = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] wclr_i,
  input  logic [NSRC-1:0] ien_i,
  output logic [NSRC-1:0] stat_q,
  output logic            irq
);
  logic [NSRC-1:0] stat_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic set_ok;
    always_comb begin
      set_ok    = set_i[i] & ien_i[i];
      // set beats a same-cycle clear
      stat_d[i] = set_ok | (stat_q[i] & ~wclr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= stat_d[i];
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[i] && ien_i[i]) |=> stat_q[i]); // R7
    AST_W1C_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wclr_i[i] && !(set_i[i] && ien_i[i])) |=> !stat_q[i]); // R7
  end

  assign irq = |(stat_q & ien_i);
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/10ps
module tick_timer #(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [tmr_pkg::DATA_W-1:0] bus_wdata,
  output logic [tmr_pkg::DATA_W-1:0] bus_rdata,
  input  logic                       dbg_active,
  output logic                       irq
);
  import tmr_pkg::*;

  localparam int NSRC = 1;
  localparam int WI_W = ADDR_W - 2;

  // reset synchronizer: asserts asynchronously, releases on clk
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // bus decode
  logic            acc_ok, wr_en;
  logic [WI_W-1:0] widx;
  logic            we_ctrl, we_stat, we_plim, we_ien, we_cmp0;

  always_comb begin
    acc_ok  = bus_sel & (bus_addr[1:0] == 2'b00);
    wr_en   = acc_ok & bus_wr;
    widx    = bus_addr[ADDR_W-1:2];
    we_ctrl = wr_en & (widx == WI_W'(WI_CTRL));
    we_stat = wr_en & (widx == WI_W'(WI_STAT));
    we_plim = wr_en & (widx == WI_W'(WI_PLIM));
    we_ien  = wr_en & (widx == WI_W'(WI_IEN));
    we_cmp0 = wr_en & (widx == WI_W'(WI_CMP0));
  end

  // software registers
  ctrl_t            ctrl_q, ctrl_d;
  logic [PRE_W-1:0] plim_q, plim_d;
  logic [NSRC-1:0]  ien_q, ien_d;
  logic [CNT_W-1:0] cmp0_q, cmp0_d;

  always_comb begin
    ctrl_d = ctrl_q;
    plim_d = plim_q;
    ien_d  = ien_q;
    cmp0_d = cmp0_q;
    if (we_ctrl) ctrl_d = ctrl_t'(bus_wdata[2:0]);
    if (we_plim) plim_d = bus_wdata[PRE_W-1:0];
    if (we_ien)  ien_d  = bus_wdata[NSRC-1:0];
    if (we_cmp0) cmp0_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q <= '0;
      plim_q <= '0;
      ien_q  <= '0;
      cmp0_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      plim_q <= plim_d;
      ien_q  <= ien_d;
      cmp0_q <= cmp0_d;
    end
  end

  // datapath
  logic             frozen, run_ok, tick;
  logic [CNT_W-1:0] cnt_val;
  logic [NSRC-1:0]  hit_vec, wclr_vec, stat_vec;

  assign frozen = ctrl_q.frz_ok & dbg_active;
  assign run_ok = ctrl_q.run & ~frozen;

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (run_ok),
    .clr   (ctrl_q.zero),
    .limit (plim_q),
    .tick  (tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     (ctrl_q.zero),
    .step    (tick),
    .cmp_val (cmp0_q),
    .cnt_q   (cnt_val),
    .hit     (hit_vec[0])
  );

  assign wclr_vec = {NSRC{we_stat}} & bus_wdata[NSRC-1:0];

  tmr_irq #(.NSRC(NSRC)) u_irq (
    .clk    (clk),
    .rst_n  (srst_n),
    .set_i  (hit_vec),
    .wclr_i (wclr_vec),
    .ien_i  (ien_q),
    .stat_q (stat_vec),
    .irq    (irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (acc_ok) begin
      case (widx)
        WI_W'(WI_CTRL): bus_rdata = DATA_W'(ctrl_q);
        WI_W'(WI_CNT):  bus_rdata = DATA_W'(cnt_val);
        WI_W'(WI_STAT): bus_rdata = DATA_W'(stat_vec);
        WI_W'(WI_PLIM): bus_rdata = DATA_W'(plim_q);
        WI_W'(WI_IEN):  bus_rdata = DATA_W'(ien_q);
        WI_W'(WI_CMP0): bus_rdata = DATA_W'(cmp0_q);
        default:        bus_rdata = '0;
      endcase
    end
  end

  AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!srst_n)
    (ctrl_q.frz_ok && dbg_active && !ctrl_q.zero) |=> $stable(cnt_val)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (!ctrl_q.run && !ctrl_q.zero) |=> $stable(cnt_val)); // R3
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(irq) |-> (stat_vec != '0)); // R6
endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/10ps
module tick_timer_bench;
  localparam int ADDR_W = 5;
  localparam int CNT_W  = 8;   // narrow counter so wraparound is reachable
  localparam logic [4:0] A_CTRL = 5'h00, A_CNT = 5'h04, A_STAT = 5'h08,
                         A_PLIM = 5'h0C, A_IEN = 5'h10, A_CMP0 = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, dbg_active, irq;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #2 clk = ~clk;

  tick_timer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(32)) u_tick_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_active(dbg_active), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  int tb_cyc = 0;
  int w0 = 0;
  bit done = 0;

  always @(posedge clk) tb_cyc <= tb_cyc + 1;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } exp_t;

  exp_t sb_q[$];
  event sample_ev;

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      @(sample_ev);
      #0.1;
      while (sb_q.size() > 0) begin
        exp_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'd0, irq} : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=0x%0h expected=0x%0h", it.req, act, it.exp);
        end
      end
    end
  end

  // driver side: push expectation, present address, let monitor sample
  task automatic expect_reg(input logic [4:0] a, input logic [31:0] e, input string r);
    exp_t it;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.req = r;
    sb_q.push_back(it);
    -> sample_ev;
    #0.2;
    bus_sel = 1'b0;
  endtask

  task automatic expect_irq(input logic e, input string r);
    exp_t it;
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.req = r;
    sb_q.push_back(it);
    -> sample_ev;
    #0.2;
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wait_until(input int k);
    while ((tb_cyc - w0) < k) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    dbg_active = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    expect_reg(A_CTRL, 0, "R10 ctrl");
    expect_reg(A_CNT,  0, "R10 cnt");
    expect_reg(A_STAT, 0, "R10 stat");
    expect_reg(A_PLIM, 0, "R10 plim");
    expect_reg(A_IEN,  0, "R10 ien");
    expect_reg(A_CMP0, 0, "R10 cmp0");
    expect_irq(1'b0, "R10 irq");
    @(negedge clk);

    // R2 divide by 4
    wr(A_PLIM, 3);
    wr(A_CTRL, 32'h1);
    w0 = tb_cyc;
    expect_reg(A_CNT, 0, "R2 start");
    wait_until(4);  expect_reg(A_CNT, 1, "R2 first step");
    wait_until(12); expect_reg(A_CNT, 3, "R2 third step");
    // R9 counter write ignored (lands on edge 13)
    wr(A_CNT, 32'h55);
    expect_reg(A_CNT, 3, "R9 write ignored");
    // R5 freeze (ctrl write on edge 14, prescaler at 2)
    wr(A_CTRL, 32'h5);
    dbg_active = 1'b1;
    wait_until(35); expect_reg(A_CNT, 3, "R5 frozen");
    dbg_active = 1'b0;
    wait_until(36); expect_reg(A_CNT, 3, "R5 resume prescaler kept");
    wait_until(37); expect_reg(A_CNT, 4, "R5 resume step");
    // R3 run bit off (lands on edge 38)
    wr(A_CTRL, 32'h4);
    wait_until(48); expect_reg(A_CNT, 4, "R3 stopped");
    // R4 zeroing with run set (lands on edge 49, clears on 50)
    wr(A_CTRL, 32'h3);
    wait_until(50); expect_reg(A_CNT, 0, "R4 cleared");
    wait_until(55); expect_reg(A_CNT, 0, "R4 held at zero");
    wr(A_CTRL, 32'h0);
    expect_reg(A_CNT, 0, "R4 after release");

    // R6 match with divide by 1, debug input high but not permitted (R5)
    wr(A_PLIM, 0);
    wr(A_CMP0, 10);
    wr(A_IEN, 1);
    dbg_active = 1'b1;
    wr(A_CTRL, 32'h1);
    w0 = tb_cyc;
    expect_reg(A_STAT, 0, "R6 idle");
    wait_until(9);
    expect_reg(A_CNT, 9, "R5 debug ignored");
    expect_reg(A_STAT, 0, "R6 before match");
    expect_irq(1'b0, "R6 irq before match");
    wait_until(10);
    expect_reg(A_STAT, 1, "R6 match sets");
    expect_irq(1'b1, "R6 irq raised");
    wait_until(15);
    expect_reg(A_CNT, 15, "R8 runs past match");
    // R7 write-one-to-clear
    wr(A_STAT, 0);
    expect_reg(A_STAT, 1, "R7 zero write no effect");
    wr(A_STAT, 1);
    expect_reg(A_STAT, 0, "R7 one clears");
    expect_irq(1'b0, "R7 irq drops");
    // R8 rewrite compare (edge 18)
    wr(A_CMP0, 25);
    wait_until(24); expect_reg(A_STAT, 0, "R8 before new match");
    wait_until(25);
    expect_reg(A_STAT, 1, "R8 new match");
    expect_irq(1'b1, "R8 irq");
    // R7 collision: clear lands on edge 30 where cnt becomes 30
    wr(A_CMP0, 30);
    wait_until(29);
    wr(A_STAT, 1);
    expect_reg(A_STAT, 1, "R7 set wins collision");
    wr(A_STAT, 1);
    expect_reg(A_STAT, 0, "R7 clear after collision");
    // R6 enable off
    wr(A_IEN, 0);
    wr(A_CMP0, 40);
    wait_until(41);
    expect_reg(A_CNT, 41, "R6 count");
    expect_reg(A_STAT, 0, "R6 disabled no set");
    expect_irq(1'b0, "R6 disabled irq");
    // R1 modulo wrap at 2^CNT_W
    wait_until(260);
    expect_reg(A_CNT, 4, "R1 wraparound");
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule